// File: doc/BRIEF.md
# Two-Wire LED Driver Bus Master

This block is the master side of a two-wire serial link to LED display and key-scan driver chips. One wire is a clock driven by the master. The other is a shared open-drain data line: the block pulls it low through an output enable and reads it back through a synchronized input.

A write request frames from one up to `MAX_BYTES` bytes. Each frame has a start condition, the bytes, a three-point acknowledge check after every byte, and a stop condition. A key request sends the read command byte, clocks in one key-scan byte and then stops.

At the end of each request the block pulses a done flag. It then reports a position-coded error number (zero on success) and, for key requests, the byte it received. All bus timing comes from one delay period, set in system clock cycles.

Top module: `twire_led_master`

## Requirements
- R1: After reset and whenever `busy` is low, the bus is idle: `bus_clk` is 1 and `bus_dat_oe` is 0. After reset, `done`, `err_code` and `key_data` are 0.
- R2: A start condition asserts `bus_dat_oe` while `bus_clk` stays high. The clock first falls exactly one delay period after that.
- R3: Write bytes go out least significant bit first. Each bit has three phases of one delay period each: clock low, data set, clock high. Data changes only while the clock is low, so the clock is low for exactly two periods per bit.
- R4: After the eighth bit the data line is released and the clock drops. The slave must read low at the check after that falling edge and again after the ninth rising edge. It must read high after the ninth falling edge. Each check samples up to 5 times, one period apart, before it fails.
- R5: When the byte just sent equals 0x42 (the key-read command), the third, released-high acknowledge check is skipped.
- R6: Error numbers are positional. For a write, byte k (counting from 0) has base 10·(k+1); a failed first, second or third acknowledge check reports base+1, +2 or +3.
- R7: A stop is issued after every request, including failed ones. The stop drives data low, raises the clock, releases data, and needs the line to read high within 5 polls; otherwise it reports 255. A byte error takes priority over a stop error. `done` is a one-cycle pulse on the cycle `busy` falls.
- R8: A key request sends 0x42 with base 230. It then clocks in 8 bits, each sampled at the end of the clock-high phase; the first bit received lands in bit 7. The read is followed by an acknowledge cycle with base 240, then a stop. `key_data` updates at `done`.
- R9: A request is accepted only while `busy` is low, and `busy` rises on the next cycle. A write with `byte_num` of 0 or greater than `MAX_BYTES` is ignored. A key request wins over a write request raised in the same cycle.
- R10: The delay period is `period_cyc` system clocks, latched at acceptance. Values below 4 are treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_cyc | input | DIVW | Delay period in system clocks |
| start_wr | input | 1 | Request a write frame |
| start_key | input | 1 | Request a key-scan read |
| byte_num | input | $clog2(MAX_BYTES+1) | Number of bytes in a write |
| payload | input | 8·MAX_BYTES | Write bytes, byte 0 in bits 7:0 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 8 | Result of the last request, 0 on success |
| key_data | output | 8 | Key byte from the last key request |
| bus_clk | output | 1 | Serial clock |
| bus_dat_oe | output | 1 | Pull data line low when 1 |
| bus_dat_in | input | 1 | Sensed level of the data line |

## Verification
The bench runs a behavioural slave on the shared line. It sends random payloads of random length at random periods, some below the clamp limit, and compares what the slave captured. That tells LSB-first from MSB-first shifting and a wrong byte order. Key reads return random values, which separates MSB-first assembly from a bit-reversed result. Directed faults cover a missing acknowledge, an early release, and a held line on bytes at several positions and on the key read. These tell the three check points apart, show whether the bases are applied by position, and show whether the 0x42 skip lets a held line surface as a stop error instead of a byte error. Ignored requests (zero count, oversize count, request while busy) are checked on the bus and on the slave's captured bytes.

// File: rtl/twire_led_master.sv
module twire_led_master #(
  parameter int DIVW = 16,
  parameter int MAX_BYTES = 4,
  localparam int CW = $clog2(MAX_BYTES + 1),
  localparam int PAYW = MAX_BYTES * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] period_cyc,
  input  logic            start_wr,
  input  logic            start_key,
  input  logic [CW-1:0]   byte_num,
  input  logic [PAYW-1:0] payload,
  output logic            busy,
  output logic            done,
  output logic [7:0]      err_code,
  output logic [7:0]      key_data,
  output logic            bus_clk,
  output logic            bus_dat_oe,
  input  logic            bus_dat_in
);

  localparam logic [7:0] KEY_CMD = 8'h42;
  localparam logic [DIVW-1:0] MIN_PER = DIVW'(4);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_BA, S_BB, S_BC, S_K1, S_K2, S_K3,
    S_RA, S_RB, S_PA, S_PB, S_PC, S_PD
  } st_t;

  st_t             st;
  logic [DIVW-1:0] cnt, per_r;
  logic [PAYW-1:0] pay_r;
  logic [7:0]      cur, base, err_r, key_r;
  logic [2:0]      bitn, poll;
  logic [CW-1:0]   left;
  logic            rd_mode, rd_ph, stop_bad;
  logic            s1, s2;

  wire             tick     = (st != S_IDLE) && (cnt == per_r - 1'b1);
  wire             skip_chk = !rd_ph && (cur == KEY_CMD);
  wire             wr_ok    = start_wr && (byte_num != '0) && (byte_num <= CW'(MAX_BYTES));
  wire [PAYW-1:0]  pay_nx   = pay_r >> 8;
  wire             last_try = (poll == 3'd4);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= bus_dat_in;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      per_r <= MIN_PER;
      pay_r <= '0;
      cur <= '0;
      base <= '0;
      err_r <= '0;
      key_r <= '0;
      bitn <= '0;
      poll <= '0;
      left <= '0;
      rd_mode <= 1'b0;
      rd_ph <= 1'b0;
      stop_bad <= 1'b0;
      bus_clk <= 1'b1;
      bus_dat_oe <= 1'b0;
      done <= 1'b0;
      err_code <= '0;
      key_data <= '0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE) cnt <= tick ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: if (start_key || wr_ok) begin
          st <= S_START;
          cnt <= '0;
          per_r <= (period_cyc < MIN_PER) ? MIN_PER : period_cyc;
          pay_r <= payload;
          rd_mode <= start_key;
          cur <= start_key ? KEY_CMD : payload[7:0];
          base <= start_key ? 8'd230 : 8'd10;
          left <= start_key ? CW'(1) : byte_num;
          rd_ph <= 1'b0;
          err_r <= '0;
          stop_bad <= 1'b0;
          key_r <= '0;
          bitn <= '0;
          poll <= '0;
          bus_dat_oe <= 1'b1;
        end
        S_START: if (tick) begin
          bus_clk <= 1'b0;
          st <= S_BA;
        end
        S_BA: if (tick) begin
          bus_dat_oe <= ~cur[bitn];
          st <= S_BB;
        end
        S_BB: if (tick) begin
          bus_clk <= 1'b1;
          st <= S_BC;
        end
        S_BC: if (tick) begin
          bus_clk <= 1'b0;
          if (bitn == 3'd7) begin
            bus_dat_oe <= 1'b0;
            poll <= '0;
            st <= S_K1;
          end else begin
            bitn <= bitn + 1'b1;
            st <= S_BA;
          end
        end
        S_K1: if (tick) begin
          if (!s2) begin
            bus_clk <= 1'b1;
            poll <= '0;
            st <= S_K2;
          end else if (last_try) begin
            err_r <= base + 8'd1;
            bus_dat_oe <= 1'b1;
            st <= S_PA;
          end else poll <= poll + 1'b1;
        end
        S_K2: if (tick) begin
          if (!s2) begin
            bus_clk <= 1'b0;
            poll <= '0;
            st <= S_K3;
          end else if (last_try) begin
            err_r <= base + 8'd2;
            bus_dat_oe <= 1'b1;
            st <= S_PA;
          end else poll <= poll + 1'b1;
        end
        S_K3: if (tick) begin
          if (skip_chk || s2) begin
            poll <= '0;
            bitn <= '0;
            if (rd_mode && !rd_ph) begin
              rd_ph <= 1'b1;
              base <= 8'd240;
              st <= S_RA;
            end else if (!rd_mode && left > CW'(1)) begin
              left <= left - 1'b1;
              pay_r <= pay_nx;
              cur <= pay_nx[7:0];
              base <= base + 8'd10;
              st <= S_BA;
            end else begin
              bus_dat_oe <= 1'b1;
              st <= S_PA;
            end
          end else if (last_try) begin
            err_r <= base + 8'd3;
            bus_dat_oe <= 1'b1;
            st <= S_PA;
          end else poll <= poll + 1'b1;
        end
        S_RA: if (tick) begin
          bus_clk <= 1'b1;
          st <= S_RB;
        end
        S_RB: if (tick) begin
          key_r <= {key_r[6:0], s2};
          bus_clk <= 1'b0;
          if (bitn == 3'd7) begin
            poll <= '0;
            st <= S_K1;
          end else begin
            bitn <= bitn + 1'b1;
            st <= S_RA;
          end
        end
        S_PA: if (tick) begin
          bus_clk <= 1'b1;
          st <= S_PB;
        end
        S_PB: if (tick) begin
          bus_dat_oe <= 1'b0;
          poll <= '0;
          st <= S_PC;
        end
        S_PC: if (tick) begin
          if (s2) st <= S_PD;
          else if (last_try) begin
            stop_bad <= 1'b1;
            st <= S_PD;
          end else poll <= poll + 1'b1;
        end
        S_PD: if (tick) begin
          st <= S_IDLE;
          done <= 1'b1;
          err_code <= (err_r != 8'd0) ? err_r : (stop_bad ? 8'd255 : 8'd0);
          if (rd_mode) key_data <= key_r;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_clk && !bus_dat_oe));

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_key) |=> busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(err_code));

  // R3
  data_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BB && !$stable(bus_dat_oe)) |-> !bus_clk);

endmodule

// File: tb/twire_led_master_tb.sv
module twire_led_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIVW = 16;
  localparam int MAXB = 4;
  localparam int CW = $clog2(MAXB + 1);

  localparam int F_NONE = 0, F_NOACK = 1, F_EARLY = 2, F_HOLD = 3;

  logic clk = 0, rst_n = 0;
  logic [DIVW-1:0] per = 16'd4;
  logic start_wr = 0, start_key = 0;
  logic [CW-1:0] byte_num = '0;
  logic [MAXB*8-1:0] payload = '0;
  logic busy, done, dut_scl, dut_oe;
  logic [7:0] err_code, key_data;
  logic s_pull = 0;
  wire line = ~(dut_oe | s_pull);

  twire_led_master #(.DIVW(DIVW), .MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .period_cyc(per), .start_wr(start_wr),
    .start_key(start_key), .byte_num(byte_num), .payload(payload),
    .busy(busy), .done(done), .err_code(err_code), .key_data(key_data),
    .bus_clk(dut_scl), .bus_dat_oe(dut_oe), .bus_dat_in(line));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural slave
  int fault = F_NONE, fb = 0;
  logic [7:0] key_val = 8'h00;
  logic [7:0] rx;
  logic [7:0] got [0:7];
  int bitc = 0, nget = 0, ackn = 0, rdc = 0;
  bit ack_ph = 0, rd = 0;

  always @(negedge line) if (dut_scl === 1'b1) begin
    bitc = 0; nget = 0; ackn = 0; rdc = 0; ack_ph = 0; rd = 0; s_pull = 0;
  end

  always @(posedge dut_scl) begin
    if (ack_ph) begin
      if (fault == F_EARLY && fb == ackn) s_pull = 0;
    end else if (!rd && bitc < 8) begin
      rx[bitc] = line;
      bitc++;
    end
  end

  always @(negedge dut_scl) begin
    if (ack_ph) begin
      ack_ph = 0;
      if (!(fault == F_HOLD && fb == ackn)) s_pull = 0;
      bitc = 0;
      if (!rd && rdc == 0) begin
        got[nget] = rx;
        nget++;
        if (nget == 1 && rx == 8'h42) begin
          rd = 1;
          s_pull = ~key_val[7];
          rdc = 1;
        end
      end else rd = 0;
      ackn++;
    end else if (rd) begin
      if (rdc < 8) begin
        s_pull = ~key_val[7-rdc];
        rdc++;
      end else begin
        ack_ph = 1;
        bitc = 8;
        s_pull = !(fault == F_NOACK && fb == ackn);
      end
    end else if (bitc == 8) begin
      ack_ph = 1;
      s_pull = !(fault == F_NOACK && fb == ackn);
    end
  end

  function automatic int eff_per(input int p);
    return (p < 4) ? 4 : p;
  endfunction

  function automatic int ack_err(input int idx, input int point);
    return 10 * (idx + 1) + point;
  endfunction

  task automatic run_op(input bit is_key, input int n, input logic [MAXB*8-1:0] pay,
                        input int flt, input int fbi, input int exp_err);
    int ta, t0, t1, w;
    bit seen;
    fault = flt; fb = fbi;
    @(negedge clk);
    payload = pay; byte_num = CW'(n);
    if (is_key) start_key = 1; else start_wr = 1;
    @(negedge clk);
    start_key = 0; start_wr = 0;
    ta = cyc;
    chk(busy === 1'b1, "R9 accept", busy, 1);
    // a request while busy must be ignored
    start_key = 1;
    @(negedge clk);
    start_key = 0;
    @(negedge dut_scl) t0 = cyc;
    chk(t0 - ta == eff_per(int'(per)) - 1 + 1 - 1 + 1, "R2 start hold", t0 - ta, eff_per(int'(per)));
    @(posedge dut_scl) t1 = cyc;
    chk(t1 - t0 == 2 * eff_per(int'(per)), "R3/R10 clock low time", t1 - t0, 2 * eff_per(int'(per)));
    seen = 0;
    for (w = 0; w < 40000 && !seen; w++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R7 done pulse", seen, 1);
    chk(err_code == 8'(exp_err), is_key ? "R8 key code" : "R6/R7 error code", err_code, exp_err);
    if (exp_err == 0 && !is_key) begin
      chk(nget == n, "R3 byte count", nget, n);
      for (int i = 0; i < n && i < 8; i++)
        chk(got[i] == pay[i*8 +: 8], "R3 LSB-first byte", got[i], pay[i*8 +: 8]);
    end
    if (exp_err == 0 && is_key) begin
      chk(got[0] == 8'h42, "R8 command", got[0], 8'h42);
      chk(key_data == key_val, "R8 key MSB first", key_data, key_val);
    end
    s_pull = 0;
    fault = F_NONE;
    @(negedge clk);
    chk(dut_scl === 1'b1 && dut_oe === 1'b0 && busy === 1'b0, "R1 idle after", {dut_scl, dut_oe}, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [MAXB*8-1:0] p;
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dut_scl === 1 && dut_oe === 0 && busy === 0 && done === 0, "R1 reset bus", {dut_scl, dut_oe}, 2);
    chk(err_code == 0 && key_data == 0, "R1 reset outputs", err_code, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R9 ignored requests: zero and oversize counts
    byte_num = '0; start_wr = 1; @(negedge clk); start_wr = 0;
    repeat (3) @(negedge clk);
    chk(busy === 0 && dut_oe === 0 && dut_scl === 1, "R9 zero count ignored", busy, 0);
    byte_num = CW'(MAXB + 1); start_wr = 1; @(negedge clk); start_wr = 0;
    repeat (3) @(negedge clk);
    chk(busy === 0 && dut_oe === 0, "R9 oversize count ignored", busy, 0);

    // R10 clamp
    per = 16'd2;
    run_op(0, 1, 32'h000000A5, F_NONE, 0, 0);
    per = 16'd0;
    run_op(0, 2, 32'h00003C81, F_NONE, 0, 0);

    // random writes
    for (int k = 0; k < 10; k++) begin
      per = 16'(4 + $urandom_range(0, 3));
      n = $urandom_range(1, MAXB);
      p = {$urandom(), $urandom()} ;
      if (p[7:0] == 8'h42) p[7:0] = 8'h43;
      run_op(0, n, p, F_NONE, 0, 0);
    end

    // random key reads (R8)
    for (int k = 0; k < 5; k++) begin
      per = 16'(4 + $urandom_range(0, 2));
      key_val = 8'($urandom());
      run_op(1, 0, '0, F_NONE, 0, 0);
    end
    key_val = 8'h81;
    run_op(1, 0, '0, F_NONE, 0, 0);

    // R4/R6 faults at several positions
    per = 16'd4;
    run_op(0, 3, 32'h00112233, F_NOACK, 0, ack_err(0, 1));
    run_op(0, 3, 32'h00112233, F_NOACK, 2, ack_err(2, 1));
    run_op(0, 2, 32'h00005566, F_EARLY, 1, ack_err(1, 2));
    run_op(0, 4, 32'h77665544, F_EARLY, 3, ack_err(3, 2));
    // R7 byte error has priority over the stop failure caused by holding
    run_op(0, 2, 32'h00009911, F_HOLD, 0, ack_err(0, 3));
    // R5: last byte 0x42 skips third check, so a held line becomes a stop error
    run_op(0, 2, 32'h00004210, F_HOLD, 1, 255);
    // R8 key read faults
    key_val = 8'h5A;
    run_op(1, 0, '0, F_NOACK, 0, 231);
    run_op(1, 0, '0, F_NOACK, 1, 241);
    run_op(1, 0, '0, F_EARLY, 1, 242);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule